// File: doc/BRIEF.md
# Edge-Latching Bridge Interrupt Controller

This block gathers interrupt events from a configurable number of sources, by default 32, and reports them to a parent interrupt controller on a single line. Each source is edge-sensitive. A low-to-high transition on a source sets a pending bit in the event register. That bit stays set until software clears it. The event register captures transitions even for sources that are disabled, so software must clear any stale pending bit before it enables a source.

Software reaches the block through a plain synchronous register port with an address, a write strobe, write data and read data. Address 0x00 holds the pending events. Address 0x04 holds the per-source enables. The request line to the parent is high while at least one pending bit is also enabled. There is no stream traffic here, so every pin is a plain control or data signal and no back-pressure applies.

Top module: `edge_irq_bridge`

## Requirements
- R1: After reset the event register (0x00) and the enable register (0x04) both read zero, and `irq_o` is low.
- R2: An event bit becomes set on the first rising clock edge at which its source is sampled high after being sampled low on the previous edge. This happens whatever the value of the matching enable bit.
- R3: A source held high produces only one event. Once that event is cleared, the bit stays clear until the source goes low and then high again.
- R4: A write to address 0x00 clears every event bit whose write-data bit is 0. Event bits whose write-data bit is 1 keep their value, and a write can never set an event bit.
- R5: If a new edge and a clearing write reach the same event bit on the same clock edge, the bit ends up set.
- R6: A write to address 0x04 loads the enable register. A 1 enables the source toward the parent and a 0 disables it. The written value reads back at 0x04.
- R7: `irq_o` equals the OR over all sources of (event bit AND enable bit). It follows register updates without an additional clock of delay.
- R8: Register bits at and above `SRC_N` read as zero and ignore writes. Addresses other than 0x00 and 0x04 read as zero, and writes to them change nothing.
- R9: Read data is combinational from the address: it shows the current register contents in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | SRC_N | Synchronous event sources |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Request to the parent controller |

## Verification
The bench uses an 8-source configuration. For every one of the 256 event patterns it checks the latched value, and it pairs each pattern with a distinct enable value so that every enable value is also covered. A design that gated latching with the enable bits would lose the events captured while disabled. A design that combined `irq_o` incorrectly would fail for one of these pattern and enable pairs.

The bench also tests a clearing write that lands on the same edge as a new event. A design that gave the write priority would drop that event. It tests a source held high across a clear. A level-sensitive design would set the bit again at once. It also checks that writing ones never sets a bit, and that writes above the implemented width or to unused addresses leave no trace in read data.

// File: rtl/eib_pkg.sv
package eib_pkg;
  localparam int DATA_W = 32;
  localparam logic [7:0] OFS_EVENT  = 8'h00;
  localparam logic [7:0] OFS_ENABLE = 8'h04;
endpackage

// File: rtl/eib_edge_detect.sv
module eib_edge_detect #(
  parameter int SRC_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_i,
  output logic [SRC_N-1:0] rise_o
);
  logic [SRC_N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/eib_event_bank.sv
module eib_event_bank #(
  parameter int SRC_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] rise_i,
  input  logic             clr_en_i,
  input  logic [SRC_N-1:0] keep_i,
  output logic [SRC_N-1:0] pend_o
);
  for (genvar b = 0; b < SRC_N; b++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pend_q <= 1'b0;
      else if (rise_i[b])            pend_q <= 1'b1;
      else if (clr_en_i && !keep_i[b]) pend_q <= 1'b0;
    end
    assign pend_o[b] = pend_q;
  end
endmodule

// File: rtl/eib_enable_reg.sv
module eib_enable_reg #(
  parameter int SRC_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SRC_N-1:0] wdata_i,
  output logic [SRC_N-1:0] en_o
);
  logic [SRC_N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge
  import eib_pkg::*;
#(
  parameter int SRC_N  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(OFS_EVENT);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  logic [SRC_N-1:0] rise_w;
  logic [SRC_N-1:0] pend_w;
  logic [SRC_N-1:0] en_w;
  logic             sel_event;
  logic             sel_enable;

  assign sel_event  = (reg_addr_i == A_EVENT);
  assign sel_enable = (reg_addr_i == A_ENABLE);

  if (SRC_N < DATA_W) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^reg_wdata_i[DATA_W-1:SRC_N];
  end

  eib_edge_detect #(.SRC_N(SRC_N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .rise_o (rise_w)
  );

  eib_event_bank #(.SRC_N(SRC_N)) u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise_w),
    .clr_en_i (reg_we_i && sel_event),
    .keep_i   (reg_wdata_i[SRC_N-1:0]),
    .pend_o   (pend_w)
  );

  eib_enable_reg #(.SRC_N(SRC_N)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (reg_we_i && sel_enable),
    .wdata_i (reg_wdata_i[SRC_N-1:0]),
    .en_o    (en_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_event)       reg_rdata_o = DATA_W'(pend_w);
    else if (sel_enable) reg_rdata_o = DATA_W'(en_w);
  end

  assign irq_o = |(pend_w & en_w);
endmodule

// File: rtl/eib_checker.sv
module eib_checker
  import eib_pkg::*;
#(
  parameter int SRC_N  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  src,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [SRC_N-1:0]  pend,
  input logic [SRC_N-1:0]  en
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'({SRC_N{1'b1}});
  logic [SRC_N-1:0] seen_q;
  logic [SRC_N-1:0] edge_c;
  logic             ev_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= src;
  end
  assign edge_c = src & ~seen_q;
  assign ev_wr  = we && (addr == ADDR_W'(OFS_EVENT));

  // R2
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c != '0) |=> ((pend & $past(edge_c)) == $past(edge_c)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> ((pend & ~$past(wdata[SRC_N-1:0]) & ~$past(edge_c)) == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wr && edge_c == '0) |=> (pend == $past(pend)));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & en) != '0));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~IMPL) == '0));
endmodule

bind edge_irq_bridge eib_checker #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_eib_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .src   (src_i),
  .addr  (reg_addr_i),
  .we    (reg_we_i),
  .wdata (reg_wdata_i),
  .rdata (reg_rdata_o),
  .irq   (irq_o),
  .pend  (pend_w),
  .en    (en_w)
);

// File: tb/test_edge_irq_bridge.sv
`timescale 1ns/1ps
module test_edge_irq_bridge;
  localparam int N = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_bridge #(.SRC_N(N), .ADDR_W(AW)) i_edge_irq_bridge (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #0.5;
    chk(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd_chk(4'h0, 32'h0, "R1 event");
    rd_chk(4'h4, 32'h0, "R1 enable");
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);

    // R2 R6 R7 R9 sweep of all patterns with a bijective enable value
    for (int p = 0; p < 256; p++) begin
      automatic logic [7:0] m = 8'((p * 37 + 11) & 255);
      wr(4'h0, 32'h0);
      src = 8'(p);
      tick();
      src = '0;
      // R9 read shows the edge captured on the previous clock edge
      rd_chk(4'h0, 32'(p), "R2 latch");
      wr(4'h4, 32'(m));
      rd_chk(4'h4, 32'(m), "R6 enable readback");
      chk(irq == |(8'(p) & m), "R7 irq", {31'b0, irq}, {31'b0, |(8'(p) & m)});
    end

    // R4 write of ones never sets, zeros clear selectively
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'h0, 32'hFF);
    rd_chk(4'h0, 32'h0, "R4 ones do not set");
    src = 8'hA5; tick(); src = '0; tick();
    wr(4'h0, 32'h3C);
    rd_chk(4'h0, 32'h24, "R4 partial clear");

    // R5 edge and clear on the same clock edge
    wr(4'h0, 32'h0);
    addr = 4'h0; wdata = 32'h0; we = 1'b1; src = 8'h04;
    tick();
    we = 1'b0; src = '0;
    rd_chk(4'h0, 32'h04, "R5 edge beats clear");

    // R3 held level latches once
    wr(4'h0, 32'h0);
    src = 8'h02; tick();
    rd_chk(4'h0, 32'h02, "R3 first edge");
    wr(4'h0, 32'h0);
    tick(); tick();
    rd_chk(4'h0, 32'h0, "R3 held level no retrigger");
    src = '0; tick();
    src = 8'h02; tick();
    rd_chk(4'h0, 32'h02, "R3 new edge");
    src = '0;

    // R8 upper bits and unused addresses
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk(4'h4, 32'h0000_00FF, "R8 enable upper bits");
    chk(irq == 1'b1, "R7 irq enabled", {31'b0, irq}, 32'h1);
    wr(4'h8, 32'h0);
    rd_chk(4'h4, 32'h0000_00FF, "R8 unused address write");
    rd_chk(4'h8, 32'h0, "R8 unused address read");
    wr(4'h0, 32'hFFFF_FF00);
    rd_chk(4'h0, 32'h0, "R8 event upper bits");
    chk(irq == 1'b0, "R7 irq cleared", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule